// File: doc/BRIEF.md
# Ring Detection Status Logic

This block sits behind the comparators of a telephone-line ring sensing front end. It receives two asynchronous comparator levels. One says that the differential ring voltage is above the positive threshold. The other says that it is below the negative threshold. After synchronising them, the block does four things:

- It drives a ring-detect pin with programmable polarity.
- It reports live positive and negative excursion status.
- It keeps a retriggerable ring-present flag with a long hold time.
- It raises interrupts when that flag asserts and at both edges of each ring pulse.

Software sets the detection mode, the pin polarity and the interrupt enables through a small write port. It acknowledges interrupts by writing ones to the pending bits. An off-hook event from the line interface drops the ring-present flag at once.

Top module: `ring_detect_status`

## Requirements
- R1: With the mode bit (control bit 0) at 0, its reset value, only a positive excursion counts as ring. A negative excursion leaves the detect pin inactive and the ring-present flag clear.
- R2: With the mode bit at 1, a positive or a negative excursion counts as ring.
- R3: The detect pin is active low while the polarity bit (control bit 1) is 0 and active high while it is 1. A new polarity shows on the pin one cycle after the write.
- R4: The positive status output is high exactly while the positive comparator is active. The negative status output follows the negative comparator in the same way. Both outputs, and the detect pin, show a comparator change three clock edges after it (two synchroniser flops and an output register).
- R5: The ring-present flag rises in the same cycle as the detect pin. Every cycle with ring active reloads a hold counter of HOLD_TICKS. The flag falls HOLD_TICKS cycles after the last active cycle, so a new pulse inside the hold window keeps it high.
- R6: An off-hook pulse clears the ring-present flag and its counter at the next clock edge.
- R7: Pending bit 0 is set when the ring-present flag asserts. It drives the interrupt only while the flag interrupt mask (control bit 2) is 1.
- R8: Pending bit 1 is set at both the beginning and the end of each ring pulse. It drives the interrupt only while the pulse interrupt enable (control bit 3) is 1.
- R9: Pending bits are sticky. Writing a 1 to bit n of address 1 clears pending bit n, and a 0 leaves it. Address 0 writes the control register.
- R10: After reset all status and pending bits and the counter are zero, and the detect pin is high (inactive for the default polarity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_pos_i | input | 1 | Asynchronous comparator: above positive threshold |
| cmp_neg_i | input | 1 | Asynchronous comparator: below negative threshold |
| offhook_i | input | 1 | Off-hook event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | 0 = control, 1 = pending clear |
| wr_data_i | input | DATA_W | Write data |
| ring_pin_o | output | 1 | Ring-detect pin level |
| stat_pos_o | output | 1 | Live positive excursion status |
| stat_neg_o | output | 1 | Live negative excursion status |
| ring_flag_o | output | 1 | Retriggerable ring-present flag |
| pend_o | output | 2 | Pending bits: 0 flag assert, 1 pulse edge |
| irq_o | output | 1 | OR of pending bits that are enabled |

## Verification
The bench applies four input patterns:

- A lone negative excursion in half-wave mode. This separates the two modes, because the status bit moves while the pin and the flag stay put.
- The same excursion in full-wave mode with an active-high pin. This shows mode and polarity acting together.
- Two positive pulses spaced inside the hold window. This separates retrigger from a single fixed timeout, since the flag must outlive the first window.
- An off-hook pulse during hold, and pulses with interrupts masked. These separate the pending state from the interrupt output.

// File: rtl/ringdet_pkg.sv
package ringdet_pkg;
  localparam int unsigned NUM_IRQ   = 2;
  localparam int unsigned IRQ_FLAG  = 0;
  localparam int unsigned IRQ_PULSE = 1;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CLR  = 1;

  typedef struct packed {
    logic pulse_en;
    logic flag_mask;
    logic pin_high;
    logic full_wave;
  } ctrl_t;
endpackage

// File: rtl/ringdet_sync.sv
module ringdet_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ringdet_hold.sv
module ringdet_hold #(
  parameter int unsigned HOLD_TICKS = 500_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_i,
  input  logic clear_i,
  output logic flag_o,
  output logic assert_o
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  assign assert_o = ring_i && !clear_i && !flag_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (ring_i) begin
      cnt_q  <= RELOAD;
      flag_q <= 1'b1;
    end else if (cnt_q == CW'(1)) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign flag_o = flag_q;

  p_flag_count_r5: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> (cnt_q != '0));
  p_offhook_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !flag_q);
endmodule

// File: rtl/ringdet_irq.sv
module ringdet_irq #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  input  logic [NUM-1:0] en_i,
  output logic [NUM-1:0] pend_o,
  output logic           irq_o
);
  logic [NUM-1:0] pend_q;

  for (genvar i = 0; i < NUM; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           pend_q[i] <= 1'b0;
      else if (set_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/ring_detect_status.sv
module ring_detect_status
  import ringdet_pkg::*;
#(
  parameter int unsigned HOLD_TICKS  = 500_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_pos_i,
  input  logic              cmp_neg_i,
  input  logic              offhook_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ring_pin_o,
  output logic              stat_pos_o,
  output logic              stat_neg_o,
  output logic              ring_flag_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t        ctrl_q;
  logic [1:0]   cmp_s;
  logic         ring_c, ring_q;
  logic         pin_q, pos_q, neg_q;
  logic         flag_assert;
  logic [NUM_IRQ-1:0] irq_set, irq_clr, irq_en;

  ringdet_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({cmp_neg_i, cmp_pos_i}), .q_o(cmp_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_CTRL))
      ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  assign ring_c = cmp_s[0] || (ctrl_q.full_wave && cmp_s[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= 1'b0;
      pin_q  <= 1'b1;
      pos_q  <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      ring_q <= ring_c;
      pin_q  <= ctrl_q.pin_high ? ring_c : !ring_c;
      pos_q  <= cmp_s[0];
      neg_q  <= cmp_s[1];
    end
  end

  ringdet_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .ring_i(ring_c), .clear_i(offhook_i),
    .flag_o(ring_flag_o), .assert_o(flag_assert)
  );

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_FLAG]  = flag_assert;
    irq_set[IRQ_PULSE] = ring_c ^ ring_q;
    irq_en = '0;
    irq_en[IRQ_FLAG]  = ctrl_q.flag_mask;
    irq_en[IRQ_PULSE] = ctrl_q.pulse_en;
    irq_clr = '0;
    if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_CLR))
      irq_clr = wr_data_i[NUM_IRQ-1:0];
  end

  ringdet_irq #(.NUM(NUM_IRQ)) u_irq (
    .clk(clk), .rst(rst), .set_i(irq_set), .clr_i(irq_clr), .en_i(irq_en),
    .pend_o(pend_o), .irq_o(irq_o)
  );

  assign ring_pin_o = pin_q;
  assign stat_pos_o = pos_q;
  assign stat_neg_o = neg_q;

  p_status_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(stat_pos_o && stat_neg_o));
  p_flag_pend_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_o[IRQ_FLAG]) |-> ring_flag_o);
  p_mask_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ctrl_q.pulse_en) |-> (pend_o[IRQ_FLAG] && ctrl_q.flag_mask));
endmodule

// File: tb/sim_ring_detect_status.sv
`timescale 1ns/1ps
module sim_ring_detect_status;
  localparam int unsigned HOLD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_pos = 1'b0, cmp_neg = 1'b0, offhook = 1'b0;
  logic wr_en = 1'b0;
  logic [0:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pin, spos, sneg, flag, irq;
  logic [1:0] pend;

  always #2.5 clk = ~clk;

  ring_detect_status #(.HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst(rst), .cmp_pos_i(cmp_pos), .cmp_neg_i(cmp_neg),
    .offhook_i(offhook), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ring_pin_o(pin), .stat_pos_o(spos),
    .stat_neg_o(sneg), .ring_flag_o(flag), .pend_o(pend), .irq_o(irq)
  );

  // observed vector: {irq, pend[1], pend[0], flag, neg, pos, pin}
  typedef struct { string req; logic [6:0] mask; logic [6:0] exp; } item_t;
  item_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [6:0] obs;
      it  = sb.pop_front();
      obs = {irq, pend, flag, sneg, spos, pin};
      n_run++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b (mask %b)", it.req, obs & it.mask,
                 it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_obs(input string req, input logic [6:0] mask, input logic [6:0] exp);
    item_t it;
    it.req = req; it.mask = mask; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  localparam logic [6:0] ALL = 7'h7F;
  localparam logic [6:0] M_PIN = 7'b0000001, M_POS = 7'b0000010, M_NEG = 7'b0000100,
                         M_FLAG = 7'b0001000, M_P0 = 7'b0010000, M_P1 = 7'b0100000,
                         M_IRQ = 7'b1000000;

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    expect_obs("R10 reset state", ALL, 7'b0000001);
    // R1: negative excursion ignored in half-wave mode
    cmp_neg = 1'b1; step(3);
    expect_obs("R1 half-wave negative", ALL, 7'b0000101);
    cmp_neg = 1'b0; step(3);
    expect_obs("R4 between thresholds", M_POS | M_NEG | M_PIN, 7'b0000001);
    // R5: positive pulse starts flag
    cmp_pos = 1'b1; step(3);
    expect_obs("R5 flag rise with pin", ALL, 7'b0111010);
    cmp_pos = 1'b0; step(3);
    expect_obs("R4 positive release", M_PIN | M_POS | M_FLAG, 7'b0001001);
    step(HOLD - 2);
    expect_obs("R5 flag held", M_FLAG, M_FLAG);
    step(1);
    expect_obs("R5 flag expired", M_FLAG, 7'b0);
    // R5 retrigger
    cmp_pos = 1'b1; step(3); cmp_pos = 1'b0; step(HOLD - 4);
    cmp_pos = 1'b1; step(3); cmp_pos = 1'b0; step(3);
    step(HOLD - 2);
    expect_obs("R5 retrigger extends hold", M_FLAG, M_FLAG);
    step(1);
    expect_obs("R5 retrigger expiry", M_FLAG, 7'b0);
    // R9 W1C
    wr(1'b1, 8'h03);
    expect_obs("R9 clear pending", M_P0 | M_P1 | M_IRQ, 7'b0);
    // R3 polarity, full-wave, masks on
    wr(1'b0, 8'h0F);
    step(1);
    expect_obs("R3 active-high idle", M_PIN, 7'b0);
    cmp_neg = 1'b1; step(3);
    expect_obs("R2 full-wave negative", ALL, 7'b1111101);
    wr(1'b1, 8'h01);
    expect_obs("R9 partial clear", M_P0 | M_P1 | M_IRQ, 7'b1100000);
    wr(1'b1, 8'h02);
    expect_obs("R8 cleared idle", M_P1 | M_IRQ, 7'b0);
    cmp_neg = 1'b0; step(3);
    expect_obs("R8 end-of-pulse edge", M_P1 | M_IRQ | M_PIN, 7'b1100000);
    // R6 off-hook
    offhook = 1'b1; step(1); offhook = 1'b0;
    expect_obs("R6 offhook clears flag", M_FLAG, 7'b0);
    step(2);
    expect_obs("R6 flag stays clear", M_FLAG, 7'b0);
    wr(1'b1, 8'h03);
    // R7 masking: interrupts disabled, pending still recorded
    wr(1'b0, 8'h03);
    cmp_pos = 1'b1; step(3);
    expect_obs("R7 masked pending", ALL, 7'b0111011);
    wr(1'b0, 8'h07);
    expect_obs("R7 mask enables irq", M_IRQ, M_IRQ);
    cmp_pos = 1'b0;
    step(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule